// File: doc/BRIEF.md
# Vectored 32-Input Interrupt Controller

This block gathers 32 interrupt request lines into two processor-facing outputs: an ordinary interrupt and a critical interrupt. Each line has a latched status bit. A per-line trigger-mode bit selects how that bit is set. In edge mode a rising input sets the bit and it stays set. In level mode the bit tracks the input whenever the input changes. An enable mask and a critical-select mask then decide which of the two outputs a pending line drives.

Software reaches the block through a single-cycle register port. A write is taken on the clock edge while `reg_we` is high. Reads are combinational from `reg_addr`. The port has no handshake, since every access completes in one cycle and the port never stalls. When the vector feature is built in (`VEC_EN`=1), the block forms a vector address for the critical source that has the highest priority. A configuration bit chooses whether priority runs from status bit 0 upward or from bit 31 downward.

Top module: `vint_ctrl`

## Requirements
- R1: After reset every register offset 0 to 15 reads 0, and both `irq_out` and `crit_out` are low.
- R2: Input line n maps to status bit (31 − n). The status can be read at offset 0 and at offset 1.
- R3: With trigger bit = 1 (edge mode), a 0→1 change on the input sets the status bit. An input held high or low leaves the bit alone, so a held-high input that has been cleared stays cleared.
- R4: With trigger bit = 0 (level mode), whenever the input changes, the status bit takes the new input value. A hidden level-shadow bit follows the input.
- R5: A write to offset 0 clears each status bit written as 1 and then ORs in the level-shadow bits, so an active level source reappears at once. A write to offset 1 ORs the written value into status.
- R6: `irq_out` is high when (status & enable & ~critical) ≠ 0, and `crit_out` is high when (status & enable & critical) ≠ 0. Offset 6 reads status & enable.
- R7: Offsets 2 (enable), 3 (critical select), 4 (polarity, stored only) and 5 (trigger mode) read back the last value written. Writes to offsets 6 and 7 change nothing. Offsets 9 to 15 read 0.
- R8: A write to offset 8 (vector configuration) stores the value with bit 1 forced to 0.
- R9: With a critical source pending and configuration bit 0 = 0, offset 7 reads (configuration with bits 1:0 cleared) + 512 × i, where i is the lowest set bit of status & enable & critical.
- R10: With configuration bit 0 = 1, offset 7 reads the same base + 512 × (31 − i), where i is the highest such set bit.
- R11: With no critical source pending, offset 7 reads 0 even when non-critical sources are pending.
- R12: A register write or an input change shows on `irq_out`, `crit_out` and the read data in the cycle right after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| irq_in | input | DW (32) | Interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register offset, used for both read and write |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Ordinary interrupt request |
| crit_out | output | 1 | Critical interrupt request |

## Verification
A corrupted status or level-shadow bit shows up on the cycle after its cause. It appears at offsets 0 and 6 and on one of the two outputs. A lost shadow bit appears only after a write-one-to-clear, when an active level source fails to return. A wrong rank in the priority scan appears at offset 7 as an error that is a multiple of 512. The sweeps therefore walk every line in both trigger modes and every critical bit in both scan directions, and they sample one cycle after each stimulus.

// File: rtl/vint_pkg.sv
package vint_pkg;

  // Register offsets; software depends on these values.
  typedef enum logic [3:0] {
    OFF_STAT   = 4'd0,
    OFF_SET    = 4'd1,
    OFF_EN     = 4'd2,
    OFF_CRIT   = 4'd3,
    OFF_POL    = 4'd4,
    OFF_TRIG   = 4'd5,
    OFF_MASKED = 4'd6,
    OFF_VEC    = 4'd7,
    OFF_VCFG   = 4'd8
  } vint_off_e;

  localparam int unsigned VINT_OFF_W = 4;

endpackage

// File: rtl/vint_capture.sv
// Per-line status and level-shadow capture.
module vint_capture #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src,       // inputs already in status-bit order
  input  logic [DW-1:0] trig,      // 1 = edge, 0 = level
  input  logic          wr_clr,
  input  logic          wr_set,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] shadow_o,
  output logic [DW-1:0] prev_o
);

  logic [DW-1:0] status_q, shadow_q, prev_q;
  logic [DW-1:0] after_wr, st_nxt, sh_nxt, rise, chg;

  // Software action first, line events applied on top of it.
  always_comb begin
    after_wr = status_q;
    if (wr_clr)      after_wr = (status_q & ~wdata) | shadow_q;
    else if (wr_set) after_wr = status_q | wdata;
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign rise[b]   = src[b] & ~prev_q[b];
    assign chg[b]    = src[b] ^ prev_q[b];
    assign st_nxt[b] = trig[b] ? (after_wr[b] | rise[b])
                               : (chg[b] ? src[b] : after_wr[b]);
    assign sh_nxt[b] = trig[b] ? shadow_q[b] : src[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      shadow_q <= '0;
      prev_q   <= '0;
    end else begin
      status_q <= st_nxt;
      shadow_q <= sh_nxt;
      prev_q   <= src;
    end
  end

  assign status_o = status_q;
  assign shadow_o = shadow_q;
  assign prev_o   = prev_q;

endmodule

// File: rtl/vint_cfg_regs.sv
// Software-written configuration registers.
module vint_cfg_regs
  import vint_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4,
  parameter bit          VEC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     en_o,
  output logic [DW-1:0]     crit_o,
  output logic [DW-1:0]     pol_o,
  output logic [DW-1:0]     trig_o,
  output logic [DW-1:0]     vcfg_o
);

  localparam logic [DW-1:0] VCFG_KEEP = ~(DW'(1) << 1);

  logic [DW-1:0] en_q, crit_q, pol_q, trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(OFF_EN))   en_q   <= wdata;
      if (addr == ADDR_W'(OFF_CRIT)) crit_q <= wdata;
      if (addr == ADDR_W'(OFF_POL))  pol_q  <= wdata;
      if (addr == ADDR_W'(OFF_TRIG)) trig_q <= wdata;
    end
  end

  if (VEC_EN) begin : g_vcfg
    logic [DW-1:0] vcfg_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  vcfg_q <= '0;
      else if (we && addr == ADDR_W'(OFF_VCFG))    vcfg_q <= wdata & VCFG_KEEP;
    end
    assign vcfg_o = vcfg_q;
  end else begin : g_no_vcfg
    assign vcfg_o = '0;
  end

  assign en_o   = en_q;
  assign crit_o = crit_q;
  assign pol_o  = pol_q;
  assign trig_o = trig_q;

endmodule

// File: rtl/vint_vector.sv
// Priority scan over pending critical sources and vector formation.
module vint_vector #(
  parameter int unsigned DW          = 32,
  parameter int unsigned STRIDE_LOG2 = 9
) (
  input  logic [DW-1:0] pend,
  input  logic [DW-1:0] cfg,
  output logic [DW-1:0] vec
);

  localparam int unsigned RW = $clog2(DW);

  logic [RW-1:0] lo_idx, hi_idx, rank;
  logic [DW-1:0] base;

  always_comb begin
    lo_idx = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (pend[i]) lo_idx = RW'(i);
    end
    hi_idx = '0;
    for (int i = 0; i < DW; i++) begin
      if (pend[i]) hi_idx = RW'(i);
    end
  end

  assign rank = cfg[0] ? (RW'(DW - 1) - hi_idx) : lo_idx;
  assign base = {cfg[DW-1:2], 2'b00};
  assign vec  = (|pend) ? (base + (DW'(rank) << STRIDE_LOG2)) : '0;

endmodule

// File: rtl/vint_ctrl.sv
// Vectored interrupt controller, top level.
module vint_ctrl
  import vint_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned ADDR_W      = VINT_OFF_W,
  parameter bit          VEC_EN      = 1'b1,
  parameter int unsigned STRIDE_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_out,
  output logic              crit_out
);

  logic [DW-1:0] in_map, status_q, shadow_q, prev_q;
  logic [DW-1:0] en_q, crit_q, pol_q, trig_q, vcfg_q;
  logic [DW-1:0] masked, pend_norm, pend_crit, vector;
  logic          wr_clr, wr_set;

  // Line n lands on status bit DW-1-n.
  for (genvar n = 0; n < DW; n++) begin : g_map
    assign in_map[DW-1-n] = irq_in[n];
  end

  assign wr_clr = reg_we && (reg_addr == ADDR_W'(OFF_STAT));
  assign wr_set = reg_we && (reg_addr == ADDR_W'(OFF_SET));

  vint_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .src(in_map), .trig(trig_q),
    .wr_clr(wr_clr), .wr_set(wr_set), .wdata(reg_wdata),
    .status_o(status_q), .shadow_o(shadow_q), .prev_o(prev_q)
  );

  vint_cfg_regs #(.DW(DW), .ADDR_W(ADDR_W), .VEC_EN(VEC_EN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en_o(en_q), .crit_o(crit_q), .pol_o(pol_q), .trig_o(trig_q), .vcfg_o(vcfg_q)
  );

  assign masked    = status_q & en_q;
  assign pend_norm = masked & ~crit_q;
  assign pend_crit = masked & crit_q;
  assign irq_out   = |pend_norm;
  assign crit_out  = |pend_crit;

  if (VEC_EN) begin : g_vec
    vint_vector #(.DW(DW), .STRIDE_LOG2(STRIDE_LOG2)) u_vec (
      .pend(pend_crit), .cfg(vcfg_q), .vec(vector)
    );
  end else begin : g_no_vec
    assign vector = '0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFF_STAT),
      ADDR_W'(OFF_SET):    reg_rdata = status_q;
      ADDR_W'(OFF_EN):     reg_rdata = en_q;
      ADDR_W'(OFF_CRIT):   reg_rdata = crit_q;
      ADDR_W'(OFF_POL):    reg_rdata = pol_q;
      ADDR_W'(OFF_TRIG):   reg_rdata = trig_q;
      ADDR_W'(OFF_MASKED): reg_rdata = masked;
      ADDR_W'(OFF_VEC):    reg_rdata = vector;
      ADDR_W'(OFF_VCFG):   reg_rdata = vcfg_q;
      default:             reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/vint_ctrl_chk.sv
// Temporal checks, attached to the top level through bind.
module vint_ctrl_chk
  import vint_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     in_map,
  input logic [DW-1:0]     prev,
  input logic [DW-1:0]     status,
  input logic [DW-1:0]     shadow,
  input logic [DW-1:0]     trig,
  input logic [DW-1:0]     en,
  input logic              crit_out,
  input logic [DW-1:0]     vector
);

  logic quiet;
  assign quiet = (in_map == prev);

  AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(OFF_SET) && quiet)
    |=> ((status & $past(reg_wdata)) == $past(reg_wdata))); // R5

  AST_CLR_REFILLS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(OFF_STAT) && quiet)
    |=> (status == (($past(status) & ~$past(reg_wdata)) | $past(shadow)))); // R5

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(in_map & ~prev & trig)) == $past(in_map & ~prev & trig))); // R3

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(~trig & (in_map ^ prev))) == $past(in_map & ~trig & (in_map ^ prev)))); // R4

  AST_STEADY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && quiet) |=> (status == $past(status))); // R3

  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_out |-> (vector == '0)); // R11

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == ADDR_W'(OFF_MASKED) || reg_addr == ADDR_W'(OFF_VEC)))
    |=> ($stable(trig) && $stable(en))); // R7

endmodule

bind vint_ctrl vint_ctrl_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .in_map(in_map), .prev(prev_q), .status(status_q),
  .shadow(shadow_q), .trig(trig_q), .en(en_q), .crit_out(crit_out),
  .vector(vector)
);

// File: tb/tb_vint_ctrl.sv
`timescale 1ns/1ps
module tb_vint_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out, crit_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .crit_out(crit_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, every offset
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    check("R1 crit_out", {31'b0, crit_out}, 32'h0);

    // R7: configuration readback, read-only offsets ignored
    wr(4'd2, 32'hA5A5_0F0F); rd(4'd2, d); check("R7 enable", d, 32'hA5A5_0F0F);
    wr(4'd3, 32'h1234_5678); rd(4'd3, d); check("R7 critical", d, 32'h1234_5678);
    wr(4'd4, 32'hDEAD_BEEF); rd(4'd4, d); check("R7 polarity", d, 32'hDEAD_BEEF);
    wr(4'd5, 32'h0F0F_F0F0); rd(4'd5, d); check("R7 trigger", d, 32'h0F0F_F0F0);
    wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd2, d); check("R7 enable after ro write", d, 32'hA5A5_0F0F);
    rd(4'd5, d); check("R7 trigger after ro write", d, 32'h0F0F_F0F0);
    rd(4'd0, d); check("R7 status after ro write", d, 32'h0);
    rd(4'd7, d); check("R7 vector after ro write", d, 32'h0);
    for (int a = 9; a < 16; a++) begin
      wr(a[3:0], 32'hFFFF_FFFF);
      rd(a[3:0], d); check("R7 unmapped reads zero", d, 32'h0);
    end

    // R8: bit 1 forced low
    wr(4'd8, 32'hFFFF_FFFF); rd(4'd8, d); check("R8 vcfg", d, 32'hFFFF_FFFD);
    wr(4'd8, 32'h0000_0002); rd(4'd8, d); check("R8 vcfg bit1", d, 32'h0);

    // R2, R3: edge sweep
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd3, 32'h0); wr(4'd5, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      drive(32'h1 << n);
      rd(4'd0, d); check("R2 R3 edge sets mapped bit", d, 32'h1 << (31 - n));
      rd(4'd1, d); check("R2 status alias", d, 32'h1 << (31 - n));
      check("R6 irq_out edge", {31'b0, irq_out}, 32'h1);
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d); check("R3 held high stays cleared", d, 32'h0);
      drive(32'h0);
      rd(4'd0, d); check("R3 falling leaves clear", d, 32'h0);
    end

    // R4, R5: level sweep
    wr(4'd5, 32'h0);
    for (int n = 0; n < 32; n++) begin
      drive(32'h1 << n);
      rd(4'd0, d); check("R4 level follows high", d, 32'h1 << (31 - n));
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d); check("R5 level reasserts after clear", d, 32'h1 << (31 - n));
      drive(32'h0);
      rd(4'd0, d); check("R4 level follows low", d, 32'h0);
    end

    // R5: status-set and partial clear
    wr(4'd1, 32'h8000_0001); rd(4'd0, d); check("R5 status set", d, 32'h8000_0001);
    wr(4'd0, 32'h8000_0000); rd(4'd0, d); check("R5 partial clear", d, 32'h0000_0001);
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, d); check("R5 full clear", d, 32'h0);

    // R6: routing
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd2, 32'h0000_00FF); wr(4'd3, 32'h0000_000F);
    wr(4'd1, 32'h0000_0101);
    rd(4'd6, d); check("R6 masked", d, 32'h0000_0001);
    check("R6 irq_out low", {31'b0, irq_out}, 32'h0);
    check("R6 crit_out high", {31'b0, crit_out}, 32'h1);
    wr(4'd1, 32'h0000_0010);
    rd(4'd6, d); check("R6 masked two", d, 32'h0000_0011);
    check("R6 irq_out high", {31'b0, irq_out}, 32'h1);
    // R12: one-cycle reaction to enable write
    wr(4'd2, 32'h0);
    check("R12 irq_out drops", {31'b0, irq_out}, 32'h0);
    check("R12 crit_out drops", {31'b0, crit_out}, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);

    // R9, R10: vector sweep
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      int j, lo, hi;
      j = (i + 5) % 32;
      lo = (i < j) ? i : j;
      hi = (i < j) ? j : i;
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'h1 << i);
      wr(4'd8, 32'h0001_0000);
      rd(4'd7, d); check("R9 ascending single", d, 32'h0001_0000 + 32'(i) * 512);
      wr(4'd8, 32'h0001_0001);
      rd(4'd7, d); check("R10 descending single", d, 32'h0001_0000 + 32'(31 - i) * 512);
      wr(4'd1, 32'h1 << j);
      rd(4'd7, d); check("R10 descending pair", d, 32'h0001_0000 + 32'(31 - hi) * 512);
      wr(4'd8, 32'h0002_0002);
      rd(4'd7, d); check("R9 ascending pair", d, 32'h0002_0000 + 32'(lo) * 512);
    end

    // R11: no critical pending
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd7, d); check("R11 vector idle", d, 32'h0);
    check("R11 crit_out idle", {31'b0, crit_out}, 32'h0);
    wr(4'd3, 32'h0);
    wr(4'd1, 32'h0000_4000);
    rd(4'd7, d); check("R11 vector with normal pending", d, 32'h0);
    check("R11 irq_out", {31'b0, irq_out}, 32'h1);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule